// File: doc/BRIEF.md
# Pointer Address Generation Unit

This unit forms the memory addresses for load and store operations that go through three pointer registers, named X, Y and Z. For each request it produces an effective address. When the addressing mode changes the pointer, it also produces the updated pointer value and says which pointer to write it back to. It also reports how many cycles the access lasts. The register file and the memory arrays sit outside the block. The pointer values arrive as inputs, and the write-back leaves as outputs.

A request is a one-cycle `start` pulse with a mode, a pointer select, a displacement and a direct address. Seven modes are supported:

- plain indirect;
- indirect with post-increment;
- indirect with pre-decrement;
- displacement from Y or Z;
- a direct constant address;
- a program-memory read through Z;
- a program-memory read through Z with post-increment.

A data access lasts two cycles and a program-memory read lasts three. The write-back strobe appears only in the last cycle.

The control is a five-state machine:

- S_IDLE waits for `start`.
- A legal request moves S_IDLE to S_FIRST. An illegal one moves S_IDLE to S_REJECT.
- S_FIRST goes to S_LAST for a data access, or to S_HOLD for a program read.
- S_HOLD always goes to S_LAST.
- S_LAST and S_REJECT both return to S_IDLE.

All request fields are captured when the request is accepted. They stay fixed until the access ends.

Top module: `ptr_agu`

## Requirements
- R1: While reset is asserted, and after its release until a request arrives, busy, done, wb_en and illegal are all 0.
- R2: Mode code 0 (plain indirect) with pointer select 0=X, 1=Y or 2=Z gives ea equal to that pointer, and wb_en stays 0 for the whole access.
- R3: Mode code 1 (post-increment) gives ea equal to the selected pointer. In the final cycle it writes back wb_val = pointer + 1 modulo 2^ADDR_W, with wb_sel equal to the pointer select.
- R4: Mode code 2 (pre-decrement) gives ea = pointer - 1 modulo 2^ADDR_W. In the final cycle it writes back that same value, with wb_sel equal to the pointer select.
- R5: Mode code 3 (displacement) with select 1 (Y) or 2 (Z) gives ea = pointer + disp modulo 2^ADDR_W with no write-back. With select 0 (X) the request is illegal.
- R6: A mode-3 request whose disp is greater than DISP_MAX (63) is illegal.
- R7: Mode code 4 (direct) gives ea = dir_addr with no write-back, whatever the pointer select, including 3.
- R8: Mode codes 5 and 6 read program memory: prog_rd=1, ea = ptr_z and cyc_total=3, whatever the select. Mode 6 also writes back ptr_z + 1 with wb_sel=2.
- R9: For a legal request, busy is 1 from the cycle after acceptance and done is 1 in its last busy cycle. A data access lasts 2 cycles (cyc_total=2) and a program read 3. Busy is 0 in the cycle after done.
- R10: wb_en is 1 only in the done cycle, and only for modes 1, 2 and 6.
- R11: Mode code 7, or select 3 with modes 0 to 3, is illegal. An illegal request pulses illegal for exactly one cycle, with busy, done and wb_en all 0.
- R12: start is ignored while busy. ea and the write-back fields keep the values captured at acceptance, even if the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when idle |
| mode | input | 3 | Addressing mode code |
| psel | input | 2 | Pointer select: 0=X, 1=Y, 2=Z |
| disp | input | DISP_IN_W | Unsigned displacement |
| dir_addr | input | ADDR_W | Direct address |
| ptr_x | input | ADDR_W | Current X pointer |
| ptr_y | input | ADDR_W | Current Y pointer |
| ptr_z | input | ADDR_W | Current Z pointer |
| busy | output | 1 | Access in progress |
| ea | output | ADDR_W | Effective address |
| prog_rd | output | 1 | Access targets program memory |
| cyc_total | output | 2 | Cycle count of the access in progress |
| done | output | 1 | Last cycle of the access |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer to write back |
| wb_val | output | ADDR_W | Updated pointer value |
| illegal | output | 1 | Rejected-request pulse |

## Verification
The bench builds the unit with ADDR_W=8, DISP_IN_W=7 and DISP_MAX=63. With those values it can sweep all 256 pointer values through every mode and select. This reaches wrap-around at both ends of the pointer range, both for increment and decrement and for displacement addition. The 7-bit displacement field also covers the rejected range 64 to 127 for every select, beside the accepted range 0 to 63.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;
    typedef enum logic [2:0] {
        M_IND     = 3'd0,
        M_POSTINC = 3'd1,
        M_PREDEC  = 3'd2,
        M_DISP    = 3'd3,
        M_DIRECT  = 3'd4,
        M_PROG    = 3'd5,
        M_PROGINC = 3'd6,
        M_RSVD    = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        P_X    = 2'd0,
        P_Y    = 2'd1,
        P_Z    = 2'd2,
        P_RSVD = 2'd3
    } psel_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FIRST,
        S_HOLD,
        S_LAST,
        S_REJECT
    } state_e;

    localparam logic [1:0] CYC_DATA = 2'd2;
    localparam logic [1:0] CYC_PROG = 2'd3;
endpackage

// File: rtl/ptr_agu_sel.sv
module ptr_agu_sel #(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        psel,
    input  logic [ADDR_W-1:0] ptr_x,
    input  logic [ADDR_W-1:0] ptr_y,
    input  logic [ADDR_W-1:0] ptr_z,
    output logic [ADDR_W-1:0] ptr_sel,
    output logic              ptr_ok
);
    import ptr_agu_pkg::*;

    always_comb begin
        ptr_ok  = 1'b1;
        ptr_sel = '0;
        unique case (psel_e'(psel))
            P_X:    ptr_sel = ptr_x;
            P_Y:    ptr_sel = ptr_y;
            P_Z:    ptr_sel = ptr_z;
            P_RSVD: ptr_ok  = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptr_agu_calc.sv
module ptr_agu_calc #(
    parameter int          ADDR_W    = 16,
    parameter int          DISP_IN_W = 8,
    parameter int unsigned DISP_MAX  = 63
) (
    input  logic [2:0]           mode,
    input  logic [1:0]           psel,
    input  logic [DISP_IN_W-1:0] disp,
    input  logic [ADDR_W-1:0]    dir_addr,
    input  logic [ADDR_W-1:0]    ptr_sel,
    input  logic                 ptr_ok,
    input  logic [ADDR_W-1:0]    ptr_z,
    output logic                 legal,
    output logic [ADDR_W-1:0]    ea_n,
    output logic                 wb_need,
    output logic [1:0]           wb_sel_n,
    output logic [ADDR_W-1:0]    wb_val_n,
    output logic                 prog
);
    import ptr_agu_pkg::*;

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] disp_ext;
    logic              disp_in_range;
    logic              disp_base_ok;

    assign disp_ext      = ADDR_W'(disp);
    assign disp_in_range = (32'(disp) <= DISP_MAX);
    assign disp_base_ok  = (psel == P_Y) || (psel == P_Z);

    always_comb begin
        legal    = ptr_ok;
        ea_n     = ptr_sel;
        wb_need  = 1'b0;
        wb_sel_n = psel;
        wb_val_n = ptr_sel;
        prog     = 1'b0;
        unique case (amode_e'(mode))
            M_IND: ;
            M_POSTINC: begin
                wb_need  = 1'b1;
                wb_val_n = ptr_sel + ONE;
            end
            M_PREDEC: begin
                wb_need  = 1'b1;
                ea_n     = ptr_sel - ONE;
                wb_val_n = ptr_sel - ONE;
            end
            M_DISP: begin
                legal = disp_base_ok && disp_in_range;
                ea_n  = ptr_sel + disp_ext;
            end
            M_DIRECT: begin
                legal = 1'b1;
                ea_n  = dir_addr;
            end
            M_PROG: begin
                legal = 1'b1;
                prog  = 1'b1;
                ea_n  = ptr_z;
            end
            M_PROGINC: begin
                legal    = 1'b1;
                prog     = 1'b1;
                ea_n     = ptr_z;
                wb_need  = 1'b1;
                wb_sel_n = P_Z;
                wb_val_n = ptr_z + ONE;
            end
            M_RSVD: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptr_agu_fsm.sv
module ptr_agu_fsm #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              legal,
    input  logic [ADDR_W-1:0] ea_n,
    input  logic              wb_need,
    input  logic [1:0]        wb_sel_n,
    input  logic [ADDR_W-1:0] wb_val_n,
    input  logic              prog,
    output logic              busy,
    output logic [ADDR_W-1:0] ea,
    output logic              prog_rd,
    output logic [1:0]        cyc_total,
    output logic              done,
    output logic              wb_en,
    output logic [1:0]        wb_sel,
    output logic [ADDR_W-1:0] wb_val,
    output logic              illegal
);
    import ptr_agu_pkg::*;

    state_e            state, state_n;
    logic              wb_need_q;
    logic              prog_q;
    logic [ADDR_W-1:0] ea_q;
    logic [1:0]        wb_sel_q;
    logic [ADDR_W-1:0] wb_val_q;
    logic              accept;

    assign accept = (state == S_IDLE) && start && legal;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q      <= '0;
            wb_need_q <= 1'b0;
            wb_sel_q  <= '0;
            wb_val_q  <= '0;
            prog_q    <= 1'b0;
        end else if (accept) begin
            ea_q      <= ea_n;
            wb_need_q <= wb_need;
            wb_sel_q  <= wb_sel_n;
            wb_val_q  <= wb_val_n;
            prog_q    <= prog;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: begin
                if (start) state_n = legal ? S_FIRST : S_REJECT;
            end
            S_FIRST:  state_n = prog_q ? S_HOLD : S_LAST;
            S_HOLD:   state_n = S_LAST;
            S_LAST:   state_n = S_IDLE;
            S_REJECT: state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        wb_en     = 1'b0;
        illegal   = 1'b0;
        cyc_total = 2'd0;
        unique case (state)
            S_IDLE: ;
            S_FIRST, S_HOLD: busy = 1'b1;
            S_LAST: begin
                busy  = 1'b1;
                done  = 1'b1;
                wb_en = wb_need_q;
            end
            S_REJECT: illegal = 1'b1;
            default: ;
        endcase
        if (busy) cyc_total = prog_q ? CYC_PROG : CYC_DATA;
    end

    assign ea      = ea_q;
    assign prog_rd = busy && prog_q;
    assign wb_sel  = wb_sel_q;
    assign wb_val  = wb_val_q;
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu #(
    parameter int          ADDR_W    = 16,
    parameter int          DISP_IN_W = 8,
    parameter int unsigned DISP_MAX  = 63
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           mode,
    input  logic [1:0]           psel,
    input  logic [DISP_IN_W-1:0] disp,
    input  logic [ADDR_W-1:0]    dir_addr,
    input  logic [ADDR_W-1:0]    ptr_x,
    input  logic [ADDR_W-1:0]    ptr_y,
    input  logic [ADDR_W-1:0]    ptr_z,
    output logic                 busy,
    output logic [ADDR_W-1:0]    ea,
    output logic                 prog_rd,
    output logic [1:0]           cyc_total,
    output logic                 done,
    output logic                 wb_en,
    output logic [1:0]           wb_sel,
    output logic [ADDR_W-1:0]    wb_val,
    output logic                 illegal
);
    logic [ADDR_W-1:0] ptr_sel;
    logic              ptr_ok;
    logic              legal;
    logic [ADDR_W-1:0] ea_n;
    logic              wb_need;
    logic [1:0]        wb_sel_n;
    logic [ADDR_W-1:0] wb_val_n;
    logic              prog;

    ptr_agu_sel #(.ADDR_W(ADDR_W)) u_sel (
        .psel(psel), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
        .ptr_sel(ptr_sel), .ptr_ok(ptr_ok)
    );

    ptr_agu_calc #(.ADDR_W(ADDR_W), .DISP_IN_W(DISP_IN_W), .DISP_MAX(DISP_MAX)) u_calc (
        .mode(mode), .psel(psel), .disp(disp), .dir_addr(dir_addr),
        .ptr_sel(ptr_sel), .ptr_ok(ptr_ok), .ptr_z(ptr_z),
        .legal(legal), .ea_n(ea_n), .wb_need(wb_need), .wb_sel_n(wb_sel_n),
        .wb_val_n(wb_val_n), .prog(prog)
    );

    ptr_agu_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .legal(legal), .ea_n(ea_n),
        .wb_need(wb_need), .wb_sel_n(wb_sel_n), .wb_val_n(wb_val_n), .prog(prog),
        .busy(busy), .ea(ea), .prog_rd(prog_rd), .cyc_total(cyc_total),
        .done(done), .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val),
        .illegal(illegal)
    );
endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [ADDR_W-1:0] ea,
    input logic              prog_rd,
    input logic              done,
    input logic              wb_en,
    input logic [ADDR_W-1:0] wb_val,
    input logic              illegal
);
    AST_WB_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done); // R10

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !done && !wb_en)); // R11

    AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal); // R11

    AST_EA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ea)); // R12

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9

    AST_DATA_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !prog_rd) |-> ($past(busy) && !$past(busy, 2))); // R9

    AST_PROG_THREE_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && prog_rd) |-> ($past(busy) && $past(busy, 2))); // R8

    AST_WB_NEAR_EA: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> ((wb_val == ea) || (wb_val == ea + ADDR_W'(1)))); // R3
endmodule

bind ptr_agu ptr_agu_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ea(ea), .prog_rd(prog_rd),
    .done(done), .wb_en(wb_en), .wb_val(wb_val), .illegal(illegal)
);

// File: tb/ptr_agu_tb.sv
module ptr_agu_tb;
    localparam int AW  = 8;
    localparam int DW  = 7;
    localparam int MOD = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    mode = '0;
    logic [1:0]    psel = '0;
    logic [DW-1:0] disp = '0;
    logic [AW-1:0] dir_addr = '0, ptr_x = '0, ptr_y = '0, ptr_z = '0;
    logic          busy, prog_rd, done, wb_en, illegal;
    logic [AW-1:0] ea, wb_val;
    logic [1:0]    cyc_total, wb_sel;

    int n_chk = 0;
    int n_bad = 0;

    ptr_agu #(.ADDR_W(AW), .DISP_IN_W(DW), .DISP_MAX(63)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .psel(psel),
        .disp(disp), .dir_addr(dir_addr), .ptr_x(ptr_x), .ptr_y(ptr_y),
        .ptr_z(ptr_z), .busy(busy), .ea(ea), .prog_rd(prog_rd),
        .cyc_total(cyc_total), .done(done), .wb_en(wb_en), .wb_sel(wb_sel),
        .wb_val(wb_val), .illegal(illegal)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_txn(input int m, input int s, input int d, input int k,
                           input int x, input int y, input int z);
        int    p, e_ea, e_wbv, e_sel, e_cyc, cnt, early;
        bit    ok, e_wb, e_prog;
        string tag;
        p      = (s == 0) ? x : (s == 1) ? y : z;
        ok     = (s != 3);
        e_ea   = p;
        e_wb   = 0;
        e_wbv  = 0;
        e_sel  = s;
        e_prog = 0;
        case (m)
            0: tag = "R2";
            1: begin tag = "R3"; e_wb = 1; e_wbv = (p + 1) % MOD; end
            2: begin tag = "R4"; e_wb = 1; e_ea = (p + MOD - 1) % MOD; e_wbv = e_ea; end
            3: begin
                tag  = (d > 63) ? "R6" : "R5";
                ok   = (s == 1 || s == 2) && (d <= 63);
                e_ea = (p + d) % MOD;
            end
            4: begin tag = "R7"; ok = 1; e_ea = k; end
            5: begin tag = "R8"; ok = 1; e_prog = 1; e_ea = z; end
            6: begin
                tag = "R8"; ok = 1; e_prog = 1; e_ea = z;
                e_wb = 1; e_wbv = (z + 1) % MOD; e_sel = 2;
            end
            default: begin tag = "R11"; ok = 0; end
        endcase
        if (!ok && m != 3 && m != 7) tag = "R11";
        e_cyc = e_prog ? 3 : 2;

        @(negedge clk);
        mode = m[2:0]; psel = s[1:0]; disp = d[DW-1:0]; dir_addr = k[AW-1:0];
        ptr_x = x[AW-1:0]; ptr_y = y[AW-1:0]; ptr_z = z[AW-1:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!ok) begin
            check({tag, " illegal pulse"}, int'(illegal), 1);
            check({tag, " R11 no busy on reject"}, int'(busy), 0);
            @(negedge clk);
            check("R11 pulse one cycle", int'(illegal), 0);
            return;
        end
        check({tag, " ea"}, int'(ea), e_ea);
        check({tag, " prog_rd"}, int'(prog_rd), int'(e_prog));
        check({tag, " cyc_total"}, int'(cyc_total), e_cyc);
        check({tag, " illegal low"}, int'(illegal), 0);
        cnt = 1; early = 0;
        while (!done && cnt < 6) begin
            if (wb_en) early = 1;
            @(negedge clk);
            cnt++;
        end
        check("R9 access length", cnt, e_cyc);
        check("R10 no early write-back", early, 0);
        check({tag, " R10 wb_en at done"}, int'(wb_en), int'(e_wb));
        if (e_wb) begin
            check({tag, " wb_val"}, int'(wb_val), e_wbv);
            check({tag, " wb_sel"}, int'(wb_sel), e_sel);
        end
        check({tag, " ea at done"}, int'(ea), e_ea);
        @(negedge clk);
        check("R9 idle after done", int'(busy), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 done in reset", int'(done), 0);
        check("R1 wb_en in reset", int'(wb_en), 0);
        check("R1 illegal in reset", int'(illegal), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 illegal after reset", int'(illegal), 0);

        for (int v = 0; v < MOD; v++)
            for (int m = 0; m < 8; m++)
                for (int s = 0; s < 4; s++)
                    if (m != 3)
                        run_txn(m, s, v % 128, (v * 7 + 3) % MOD,
                                v, v ^ 90, (v + 37) % MOD);

        for (int d = 0; d < 128; d++)
            for (int s = 0; s < 4; s++) begin
                run_txn(3, s, d, 0, 17, 0, 200);
                run_txn(3, s, d, 0, 255, 255, 255);
                run_txn(3, s, d, 0, 0, 130, 1);
            end

        // R12: start held and inputs changed during a post-increment access
        @(negedge clk);
        mode = 3'd1; psel = 2'd1; ptr_y = 8'd40; start = 1'b1;
        @(negedge clk);
        mode = 3'd4; dir_addr = 8'd99; ptr_y = 8'd7; psel = 2'd2;
        check("R12 ea captured", int'(ea), 40);
        @(negedge clk);
        check("R12 done", int'(done), 1);
        check("R12 wb_val captured", int'(wb_val), 41);
        check("R12 wb_sel captured", int'(wb_sel), 1);
        check("R12 ea held", int'(ea), 40);
        start = 1'b0;
        @(negedge clk);
        check("R12 start ignored while busy", int'(busy), 0);
        check("R12 no reject", int'(illegal), 0);
        @(negedge clk);
        check("R12 still idle", int'(busy), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule